// File: doc/BRIEF.md
# Time-Shared Partial-Product FIR Filter

This block is a long single-channel FIR filter for audio-rate streams. The audio rate is far below the core clock, so one narrow multiplier is reused for every tap. Each 24-bit input sample arrives with a one-cycle valid strobe. The sample is written into a circular history memory. The block then walks the taps in sequence, newest sample first. For each tap it reads one coefficient from an on-chip coefficient memory.

Each 24x24 tap product is split into four 12x12 partial products, one per clock cycle. The upper halves are treated as signed and the lower halves as unsigned. Each partial product is registered, sign-extended, weighted by 0, 12 or 24 bit positions and added into a wide accumulator. The accumulator cannot overflow across all taps. After the last tap, the accumulator is scaled down by a parameterised amount and clipped to 24 bits. The result is presented with a one-cycle valid strobe.

Coefficients are loaded through a plain write port. A `busy` flag reports that a computation is running. A sample that arrives while `busy` is high is held and starts the next computation.

Top module: `fir_pp_top`

## Requirements
- R1: Each output equals sat((sum over k of c[k]·x[n-k]) >>> OUT_SHIFT), with OUT_SHIFT defaulting to 23, where:
   - samples and coefficients are 24-bit two's complement values;
   - c[k] is the coefficient stored at coefficient address k;
   - x[n] is the newest accepted sample (k = 0);
   - the product of the two most negative values, -2^23 · -2^23 = 2^46, is formed exactly.
- R2: The sample history reads as zero after reset. Each accepted sample advances the history by exactly one position, and the history wraps modulo TAPS, so a sample older than TAPS-1 positions contributes nothing.
- R3: `out_valid` goes high exactly 4·TAPS+2 clock edges after the edge that accepts a sample, and stays high for one cycle only.
- R4: An output whose scaled value lies above 2^23-1 is reported as 0x7FFFFF. One below -2^23 is reported as 0x800000.
- R5: `busy` is high from the cycle after a sample is accepted. It falls in the same cycle that `out_valid` is asserted.
- R6: A sample whose strobe comes while `busy` is high is held, and a later strobe during the same computation replaces the held value. The held sample is accepted on the edge that ends the `out_valid` cycle, so the next `out_valid` comes 4·TAPS+3 cycles after the previous one.
- R7: With `coef_we` high, `coef_data` is written to coefficient address `coef_addr` on the clock edge. The new value is used by the next computation.
- R8: During and right after reset, `out_valid` and `busy` are 0 and `out_sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | One-cycle strobe for a new input sample |
| in_sample | input | DATA_W | Input sample, two's complement |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | log2(TAPS) | Coefficient address (tap index, 0 = newest sample) |
| coef_data | input | DATA_W | Coefficient value, two's complement |
| out_valid | output | 1 | One-cycle strobe for a finished output |
| out_sample | output | DATA_W | Filtered, scaled and saturated output |
| busy | output | 1 | A computation is in progress |

## Verification
- An impulse against a sparse coefficient set shows that each coefficient lines up with the right history position and that the history starts at zero.
- Operands of extreme sign isolate the signed-high/unsigned-low recombination of the partial products. The same operands, pushed further, drive both saturation limits.
- Three strobes sent during one computation tell apart dropping, queueing and replacing a held sample. They also show the one-cycle restart gap.
- A long run of random samples drives the history through several wraps. Small random coefficients keep the outputs in range, then full-range coefficients mix exact and clipped results.

// File: rtl/fir_pp_pkg.sv
package fir_pp_pkg;

   // Tag that travels with each multiply step through the pipeline
   typedef struct packed {
      logic       valid;
      logic [1:0] phase;   // bit1: upper sample half, bit0: upper coefficient half
      logic       first;   // first step of a computation: accumulator restarts
      logic       last;    // last step of a computation: output is produced
   } fir_pp_tag_t;

   localparam int STEPS_PER_TAP = 4;

endpackage

// File: rtl/fir_pp_ram.sv
module fir_pp_ram #(
   parameter int WIDTH = 24,
   parameter int DEPTH = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [WIDTH-1:0]         wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [WIDTH-1:0]         rdata
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("fir_pp_ram: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
         end
         rdata <= '0;
      end else begin
         if (we) begin
            mem[waddr] <= wdata;
         end
         rdata <= mem[raddr];
      end
   end

endmodule

// File: rtl/fir_pp_seq.sv
module fir_pp_seq
   import fir_pp_pkg::*;
#(
   parameter int TAPS   = 1024,
   parameter int DATA_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [DATA_W-1:0]       in_sample,
   input  logic                    done,
   output logic                    wr_en,
   output logic [$clog2(TAPS)-1:0] wr_addr,
   output logic [DATA_W-1:0]       wr_data,
   output logic [$clog2(TAPS)-1:0] s_raddr,
   output logic [$clog2(TAPS)-1:0] c_raddr,
   output fir_pp_tag_t             tag_q,
   output logic                    busy
);
   localparam int AW    = $clog2(TAPS);
   localparam int STEPS = STEPS_PER_TAP * TAPS;
   localparam int CNT_W = $clog2(STEPS);
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

   logic [CNT_W-1:0]  cnt;
   logic              issuing;
   logic              busy_q;
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     newest;
   logic              pend_v;
   logic [DATA_W-1:0] pend_d;
   logic              src_valid;
   logic [DATA_W-1:0] src_data;
   logic              start;
   logic [AW-1:0]     tap_idx;

   always_comb begin
      src_valid = pend_v | in_valid;
      src_data  = pend_v ? pend_d : in_sample;
      start     = src_valid & ~busy_q;
      tap_idx   = cnt[CNT_W-1:2];
      wr_en     = start;
      wr_addr   = wr_ptr;
      wr_data   = src_data;
      s_raddr   = newest - tap_idx;
      c_raddr   = tap_idx;
      busy      = busy_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         issuing <= 1'b0;
         busy_q  <= 1'b0;
         wr_ptr  <= '0;
         newest  <= '0;
         pend_v  <= 1'b0;
         pend_d  <= '0;
         tag_q   <= '0;
      end else begin
         if (start) begin
            busy_q  <= 1'b1;
            issuing <= 1'b1;
            cnt     <= '0;
            newest  <= wr_ptr;
            wr_ptr  <= wr_ptr + AW'(1);
         end else begin
            if (done) begin
               busy_q <= 1'b0;
            end
            if (issuing) begin
               cnt <= cnt + CNT_W'(1);
               if (cnt == LAST_STEP) begin
                  issuing <= 1'b0;
               end
            end
         end

         if (start) begin
            pend_v <= pend_v & in_valid;
            if (pend_v && in_valid) begin
               pend_d <= in_sample;
            end
         end else if (in_valid) begin
            pend_v <= 1'b1;
            pend_d <= in_sample;
         end

         tag_q.valid <= issuing;
         tag_q.phase <= cnt[1:0];
         tag_q.first <= issuing && (cnt == '0);
         tag_q.last  <= issuing && (cnt == LAST_STEP);
      end
   end

   // R5
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy_q && issuing));

   // R6
   held_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_v && busy_q && !in_valid) |=> (pend_v && $stable(pend_d)));

endmodule

// File: rtl/fir_pp_mac.sv
module fir_pp_mac
   import fir_pp_pkg::*;
#(
   parameter int TAPS      = 1024,
   parameter int DATA_W    = 24,
   parameter int OUT_SHIFT = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fir_pp_tag_t       tag_i,
   input  logic [DATA_W-1:0] sample_i,
   input  logic [DATA_W-1:0] coef_i,
   output logic              done_o,
   output logic [DATA_W-1:0] y_o,
   output logic              y_valid_o
);
   localparam int HALF   = DATA_W / 2;
   localparam int OP_W   = HALF + 1;
   localparam int PP_W   = 2 * OP_W;
   localparam int PROD_W = 2 * DATA_W;
   localparam int ACC_W  = PROD_W + $clog2(TAPS);

   generate
      if (DATA_W % 2 != 0 || DATA_W < 4) begin : g_bad_width
         $error("fir_pp_mac: DATA_W must be even and at least 4");
      end
      if (OUT_SHIFT < 0 || OUT_SHIFT > PROD_W - 1) begin : g_bad_shift
         $error("fir_pp_mac: OUT_SHIFT out of range");
      end
   endgenerate

   // Stage 1: select halves and multiply
   logic signed [OP_W-1:0] a_op;
   logic signed [OP_W-1:0] b_op;
   logic signed [PP_W-1:0] pp_c;

   always_comb begin
      if (tag_i.phase[1]) a_op = {sample_i[DATA_W-1], sample_i[DATA_W-1:HALF]};
      else                a_op = {1'b0, sample_i[HALF-1:0]};
      if (tag_i.phase[0]) b_op = {coef_i[DATA_W-1], coef_i[DATA_W-1:HALF]};
      else                b_op = {1'b0, coef_i[HALF-1:0]};
      pp_c = a_op * b_op;
   end

   logic signed [PP_W-1:0] pp_q;
   logic                   pp_valid;
   logic                   pp_first;
   logic                   pp_last;
   logic [1:0]             pp_shift;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pp_q     <= '0;
         pp_valid <= 1'b0;
         pp_first <= 1'b0;
         pp_last  <= 1'b0;
         pp_shift <= '0;
      end else begin
         pp_q     <= pp_c;
         pp_valid <= tag_i.valid;
         pp_first <= tag_i.first;
         pp_last  <= tag_i.last;
         pp_shift <= {1'b0, tag_i.phase[1]} + {1'b0, tag_i.phase[0]};
      end
   end

   // Stage 2: scaling accumulator
   logic signed [ACC_W-1:0] pp_ext;
   logic signed [ACC_W-1:0] term;
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] acc_sum;
   logic signed [ACC_W-1:0] scaled;
   logic [DATA_W-1:0]       y_sat;

   always_comb begin
      pp_ext = {{(ACC_W-PP_W){pp_q[PP_W-1]}}, pp_q};
      case (pp_shift)
         2'd0:    term = pp_ext;
         2'd1:    term = pp_ext <<< HALF;
         default: term = pp_ext <<< (2 * HALF);
      endcase
      acc_sum = pp_first ? term : (acc_q + term);
      scaled  = acc_sum >>> OUT_SHIFT;
      if ((&scaled[ACC_W-1:DATA_W-1]) || !(|scaled[ACC_W-1:DATA_W-1])) begin
         y_sat = scaled[DATA_W-1:0];
      end else if (scaled[ACC_W-1]) begin
         y_sat = {1'b1, {(DATA_W-1){1'b0}}};
      end else begin
         y_sat = {1'b0, {(DATA_W-1){1'b1}}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         y_o       <= '0;
         y_valid_o <= 1'b0;
      end else begin
         if (pp_valid) begin
            acc_q <= acc_sum;
         end
         y_valid_o <= pp_valid && pp_last;
         if (pp_valid && pp_last) begin
            y_o <= y_sat;
         end
      end
   end

   assign done_o = pp_valid && pp_last;

   // R1
   first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && pp_first) |-> (pp_shift == 2'd0));

   // R1
   last_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pp_valid && pp_last) |-> (pp_shift == 2'd2));

endmodule

// File: rtl/fir_pp_top.sv
module fir_pp_top
   import fir_pp_pkg::*;
#(
   parameter int TAPS      = 1024,
   parameter int DATA_W    = 24,
   parameter int OUT_SHIFT = 23
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [DATA_W-1:0]       in_sample,
   input  logic                    coef_we,
   input  logic [$clog2(TAPS)-1:0] coef_addr,
   input  logic [DATA_W-1:0]       coef_data,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_sample,
   output logic                    busy
);
   localparam int AW = $clog2(TAPS);

   logic              s_we;
   logic [AW-1:0]     s_waddr;
   logic [DATA_W-1:0] s_wdata;
   logic [AW-1:0]     s_raddr;
   logic [AW-1:0]     c_raddr;
   logic [DATA_W-1:0] s_rdata;
   logic [DATA_W-1:0] c_rdata;
   fir_pp_tag_t       tag;
   logic              done;

   fir_pp_seq #(.TAPS(TAPS), .DATA_W(DATA_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .done(done), .wr_en(s_we), .wr_addr(s_waddr), .wr_data(s_wdata),
      .s_raddr(s_raddr), .c_raddr(c_raddr), .tag_q(tag), .busy(busy)
   );

   fir_pp_ram #(.WIDTH(DATA_W), .DEPTH(TAPS)) hist_ram_i (
      .clk(clk), .rst_n(rst_n), .we(s_we), .waddr(s_waddr), .wdata(s_wdata),
      .raddr(s_raddr), .rdata(s_rdata)
   );

   fir_pp_ram #(.WIDTH(DATA_W), .DEPTH(TAPS)) coef_ram_i (
      .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_addr), .wdata(coef_data),
      .raddr(c_raddr), .rdata(c_rdata)
   );

   fir_pp_mac #(.TAPS(TAPS), .DATA_W(DATA_W), .OUT_SHIFT(OUT_SHIFT)) mac_i (
      .clk(clk), .rst_n(rst_n), .tag_i(tag), .sample_i(s_rdata), .coef_i(c_rdata),
      .done_o(done), .y_o(out_sample), .y_valid_o(out_valid)
   );

   // R3
   out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R5
   busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> out_valid);

endmodule

// File: tb/fir_pp_top_tb_top.sv
module fir_pp_top_tb_top;
   localparam int T     = 16;
   localparam int DW    = 24;
   localparam int SH    = 23;
   localparam int AW    = $clog2(T);
   localparam int LAT   = 4 * T + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_sample = '0;
   logic          coef_we = 1'b0;
   logic [AW-1:0] coef_addr = '0;
   logic [DW-1:0] coef_data = '0;
   logic          out_valid;
   logic [DW-1:0] out_sample;
   logic          busy;

   int     n_cmp = 0;
   int     n_bad = 0;
   longint hist [T];
   longint cm   [T];
   int     hp = 0;

   always #5 clk = ~clk;

   fir_pp_top #(.TAPS(T), .DATA_W(DW), .OUT_SHIFT(SH)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
      .out_valid(out_valid), .out_sample(out_sample), .busy(busy)
   );

   function automatic longint sx(logic [DW-1:0] v);
      return {{(64-DW){v[DW-1]}}, v};
   endfunction

   function automatic logic [DW-1:0] sat_model(longint s);
      longint sh;
      sh = s >>> SH;
      if (sh > 64'sd8388607)  return 24'h7FFFFF;
      if (sh < -64'sd8388608) return 24'h800000;
      return sh[DW-1:0];
   endfunction

   function automatic logic [DW-1:0] expected();
      longint s = 0;
      for (int k = 0; k < T; k++) s += cm[k] * hist[(hp - k + T) % T];
      return sat_model(s);
   endfunction

   task automatic chk(string req, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(logic [DW-1:0] x);
      hp = (hp + 1) % T;
      hist[hp] = sx(x);
   endtask

   task automatic put_coef(int idx, logic [DW-1:0] v);
      @(negedge clk);
      coef_we = 1'b1; coef_addr = AW'(idx); coef_data = v;
      @(posedge clk); #1;
      coef_we = 1'b0;
      cm[idx] = sx(v);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   // waits for out_valid from the current negedge; returns negedges counted
   task automatic wait_out(output int k);
      k = 0;
      while (!out_valid && k < 5000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic send_check(logic [DW-1:0] x, string req);
      logic [DW-1:0] e;
      int k;
      wait_idle();
      in_valid = 1'b1; in_sample = x;
      @(posedge clk); #1;
      in_valid = 1'b0;
      push(x);
      e = expected();
      @(negedge clk);
      if (!out_valid) begin
         // R5 busy high while computing
         n_cmp++;
         if (!busy) begin n_bad++; $display("FAIL R5 busy actual=0 expected=1"); end
      end
      wait_out(k);
      // R3 latency from accepting edge
      chk({"R3 latency ", req}, k, LAT);
      chk(req, sx(out_sample), sx(e));
      // R5 busy falls with out_valid
      chk("R5 busy at out_valid", busy, 0);
      @(negedge clk);
      chk("R3 pulse width", out_valid, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] e1, e3;
      int k;
      void'($urandom(32'd611));
      for (int i = 0; i < T; i++) begin hist[i] = 0; cm[i] = 0; end

      // R8 reset state
      repeat (3) @(negedge clk);
      chk("R8 out_valid in reset", out_valid, 0);
      chk("R8 busy in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 out_valid after reset", out_valid, 0);
      chk("R8 busy after reset", busy, 0);
      chk("R8 out_sample after reset", sx(out_sample), 0);

      // R2 impulse: history starts at zero, each tap lines up
      put_coef(0, 24'h200000);
      put_coef(3, 24'h400000);
      send_check(24'h7FFFFF, "R2 impulse head");
      for (int i = 0; i < 5; i++) send_check(24'h000000, "R2 impulse tail");

      // R1 extreme-sign recombination and R7 coefficient update
      for (int i = 0; i < T; i++) put_coef(i, 24'h000000);
      put_coef(0, 24'h800000);
      send_check(24'h7FFFFF, "R1 max times min");
      send_check(24'h800000, "R4 min times min saturates high");
      put_coef(0, 24'h7FFFFF);
      put_coef(1, 24'h7FFFFF);
      send_check(24'h800000, "R7 new coefficients used");
      send_check(24'h800000, "R4 saturates low");

      // R6 held sample: second strobe is replaced by the third
      put_coef(1, 24'h012345);
      put_coef(2, 24'hFEDCBA);
      wait_idle();
      in_valid = 1'b1; in_sample = 24'h123456;
      @(posedge clk); #1;
      in_valid = 1'b0;
      push(24'h123456);
      e1 = expected();
      repeat (3) @(negedge clk);
      chk("R6 busy while held", busy, 1);
      in_valid = 1'b1; in_sample = 24'h0ABCDE;
      @(posedge clk); #1;
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
      in_valid = 1'b1; in_sample = 24'hF00F00;
      @(posedge clk); #1;
      in_valid = 1'b0;
      push(24'hF00F00);
      e3 = expected();
      @(negedge clk);
      wait_out(k);
      chk("R6 output before held", sx(out_sample), sx(e1));
      @(negedge clk);
      chk("R6 held starts at once", busy, 1);
      k = 1;
      while (!out_valid && k < 5000) begin @(negedge clk); k++; end
      chk("R6 restart gap", k, LAT + 1);
      chk("R6 held newest value used", sx(out_sample), sx(e3));

      // R2 wrap and R1 with random samples, small coefficients
      for (int i = 0; i < T; i++) put_coef(i, DW'(sx(16'($urandom))));
      for (int n = 0; n < 40; n++) send_check(DW'($urandom), "R2 R1 random wrap");

      // R4 R1 full-range coefficients
      for (int i = 0; i < T; i++) put_coef(i, DW'($urandom));
      for (int n = 0; n < 10; n++) send_check(DW'($urandom), "R1 R4 full range");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule